// File: doc/BRIEF.md
# Page-Buffered Write Engine with Address Counter

This block sits behind a two-wire serial memory interface and owns everything between the decoded bus events and the storage array. It keeps a 13-bit word-address counter and gathers incoming data bytes into a 32-byte page buffer. When the transfer ends, it runs a self-timed commit that copies the received bytes into the array. The interface gives it strobes for "address loaded", "data byte received", "read byte consumed" and "STOP seen". The block gives back the current address, a busy flag and a single write port toward the array.

The array holds 8192 bytes, arranged as 256 pages of 32 bytes. An address is an 8-bit page number in bits 12..5 above a 5-bit byte offset in bits 4..0.
- **Writes:** only the offset advances, so a long burst wraps around and overwrites within its own page.
- **Reads:** the whole address advances and rolls over from 0x1FFF to 0x0000.

A STOP that closes a transfer holding at least one received byte starts a busy interval of `BUSY_CYCLES` clock cycles. The interface uses the busy flag to withhold acknowledges, so a bus master can poll until the flag drops. During busy every strobe is ignored. The first `PAGE_BYTES` cycles of busy scan the buffer in offset order and write only the lanes that received data. `BUSY_CYCLES` must therefore be at least the page size. When the write-protect pin is high at the STOP and the page lies in the top quarter (addresses 0x1800..0x1FFF), the busy interval still runs but nothing reaches the array.

Top module: `pageWriteEngine`

## Requirements
- R1: After reset, curAddr is 0, busy is 0 and memWrEn is 0.
- R2: An addrLoadStb while not busy sets curAddr to addrLoadVal on the next cycle. A pending uncommitted byte set is discarded by such a load.
- R3: A wrByteStb while not busy stores the byte at the current offset. It then increments curAddr bits 4..0 modulo 32 and leaves bits 12..5 unchanged. The counter keeps the resulting value after the commit.
- R4: A rdAdvStb while not busy, with no load or byte strobe in the same cycle, increments the full 13-bit curAddr, so that 0x1FFF is followed by 0x0000.
- R5: A stopStb while not busy, with at least one byte received since the last load or commit, raises busy on the next cycle for exactly BUSY_CYCLES cycles. A stopStb with no received byte leaves busy low.
- R6: During busy, memWrEn pulses once for each received offset, in ascending offset order. Each pulse carries memWrAddr = {page, offset} and the last byte written to that offset. Offsets that received no byte are never written.
- R7: If wpIn is 1 in the cycle of the starting stopStb and address bits 12..11 of the page are both 1, no memWrEn pulse occurs in that busy interval. With wpIn 0, or with a page below 0x1800, the commit proceeds.
- R8: While busy is 1, addrLoadStb, wrByteStb, rdAdvStb and stopStb have no effect. curAddr stays unchanged, and no byte offered then is committed or starts a later busy interval.
- R9: A wrByteStb in the same cycle as the stopStb that ends the transfer is captured and included in the commit it starts.
- R10: A load after bytes were received but before a STOP drops those bytes, so that a following stopStb starts no busy interval and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrLoadStb | input | 1 | Word address received, load the counter |
| addrLoadVal | input | 13 | Word address to load |
| wrByteStb | input | 1 | Data byte received in a write transfer |
| wrByteVal | input | 8 | Received data byte |
| rdAdvStb | input | 1 | A read byte was sent, advance the counter |
| stopStb | input | 1 | STOP condition seen on the bus |
| wpIn | input | 1 | Write-protect pin for the top quarter |
| busy | output | 1 | Commit interval in progress, withhold acknowledges |
| curAddr | output | 13 | Current word address (read start address) |
| memWrEn | output | 1 | Array write enable |
| memWrAddr | output | 13 | Array write address |
| memWrData | output | 8 | Array write data |

## Verification
Byte capture and commit start can occur in the same cycle when the final data byte and the STOP arrive together. The bench provokes this by driving wrByteStb and stopStb in one cycle after an earlier byte. The result is judged by the commit: it must contain both offsets, carry the last byte's value, and last the full busy length. A second collision is strobes that arrive while the commit runs. The bench judges this from curAddr, from the write log, and from a later STOP that must stay idle.

// File: rtl/pageWritePkg.sv
`timescale 1ns/1ps
package pageWritePkg;
  localparam int unsigned OFF_BITS   = 5;
  localparam int unsigned PAGE_BITS  = 8;
  localparam int unsigned ADDR_BITS  = PAGE_BITS + OFF_BITS;
  localparam int unsigned PAGE_BYTES = 1 << OFF_BITS;
  localparam int unsigned DATA_BITS  = 8;
  // number of page-number MSBs that select the protected quarter
  localparam int unsigned PROT_BITS  = 2;

  typedef struct packed {
    logic                loadAddr;
    logic                takeByte;
    logic                advRead;
    logic                clearPend;
    logic                commitEn;
    logic [OFF_BITS-1:0] commitIdx;
  } engStrobe_t;
endpackage

// File: rtl/pageWriteCtl.sv
`timescale 1ns/1ps
module pageWriteCtl
  import pageWritePkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 250000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 addrLoadStb,
  input  logic                 wrByteStb,
  input  logic                 rdAdvStb,
  input  logic                 stopStb,
  input  logic                 wpIn,
  input  logic                 pendAny,
  input  logic [PAGE_BITS-1:0] curPage,
  output logic                 busy,
  output engStrobe_t           strb
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BUSY_CYCLES - 1);
  localparam logic [CNT_W-1:0] SCAN_END = CNT_W'(PAGE_BYTES);

  logic             busyQ;
  logic             protQ;
  logic [CNT_W-1:0] cntQ;
  logic             idle;
  logic             lastCycle;
  logic             protNow;
  logic             startCommit;

  always_comb begin
    idle           = !busyQ;
    strb.loadAddr  = idle && addrLoadStb;
    strb.takeByte  = idle && wrByteStb && !addrLoadStb;
    strb.advRead   = idle && rdAdvStb && !addrLoadStb && !wrByteStb;
    lastCycle      = busyQ && (cntQ == LAST_CNT);
    strb.clearPend = lastCycle || strb.loadAddr;
    strb.commitEn  = busyQ && !protQ && (cntQ < SCAN_END);
    strb.commitIdx = cntQ[OFF_BITS-1:0];
    protNow        = wpIn && (&curPage[PAGE_BITS-1 -: PROT_BITS]);
    startCommit    = idle && stopStb && !addrLoadStb && (pendAny || strb.takeByte);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      protQ <= 1'b0;
      cntQ  <= '0;
    end else if (startCommit) begin
      busyQ <= 1'b1;
      protQ <= protNow;
      cntQ  <= '0;
    end else if (lastCycle) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (busyQ) begin
      cntQ  <= cntQ + 1'b1;
    end
  end

  assign busy = busyQ;
endmodule

// File: rtl/pageWriteDp.sv
`timescale 1ns/1ps
module pageWriteDp
  import pageWritePkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  engStrobe_t           strb,
  input  logic [ADDR_BITS-1:0] addrLoadVal,
  input  logic [DATA_BITS-1:0] wrByteVal,
  output logic [ADDR_BITS-1:0] curAddr,
  output logic [PAGE_BITS-1:0] curPage,
  output logic                 pendAny,
  output logic                 memWrEn,
  output logic [ADDR_BITS-1:0] memWrAddr,
  output logic [DATA_BITS-1:0] memWrData
);
  logic [ADDR_BITS-1:0]  addrQ;
  logic [OFF_BITS-1:0]   offset;
  logic [PAGE_BYTES-1:0] pendVec;
  logic [DATA_BITS-1:0]  laneData [PAGE_BYTES];

  assign offset = addrQ[OFF_BITS-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (strb.loadAddr) begin
      addrQ <= addrLoadVal;
    end else if (strb.takeByte) begin
      addrQ[OFF_BITS-1:0] <= offset + 1'b1;
    end else if (strb.advRead) begin
      addrQ <= addrQ + 1'b1;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gLane
    logic                 hitLane;
    logic                 pendQ;
    logic [DATA_BITS-1:0] dataQ;

    assign hitLane = strb.takeByte && (offset == OFF_BITS'(g));

    always_ff @(posedge clk) begin
      if (hitLane) dataQ <= wrByteVal;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               pendQ <= 1'b0;
      else if (strb.clearPend) pendQ <= 1'b0;
      else if (hitLane)        pendQ <= 1'b1;
    end

    assign pendVec[g]  = pendQ;
    assign laneData[g] = dataQ;
  end

  assign curAddr   = addrQ;
  assign curPage   = addrQ[ADDR_BITS-1:OFF_BITS];
  assign pendAny   = |pendVec;
  assign memWrEn   = strb.commitEn && pendVec[strb.commitIdx];
  assign memWrAddr = {addrQ[ADDR_BITS-1:OFF_BITS], strb.commitIdx};
  assign memWrData = laneData[strb.commitIdx];
endmodule

// File: rtl/pageWriteEngine.sv
`timescale 1ns/1ps
module pageWriteEngine
  import pageWritePkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 250000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 addrLoadStb,
  input  logic [ADDR_BITS-1:0] addrLoadVal,
  input  logic                 wrByteStb,
  input  logic [DATA_BITS-1:0] wrByteVal,
  input  logic                 rdAdvStb,
  input  logic                 stopStb,
  input  logic                 wpIn,
  output logic                 busy,
  output logic [ADDR_BITS-1:0] curAddr,
  output logic                 memWrEn,
  output logic [ADDR_BITS-1:0] memWrAddr,
  output logic [DATA_BITS-1:0] memWrData
);
  engStrobe_t           strb;
  logic                 pendAny;
  logic [PAGE_BITS-1:0] curPage;

  pageWriteCtl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN),
    .addrLoadStb(addrLoadStb), .wrByteStb(wrByteStb), .rdAdvStb(rdAdvStb),
    .stopStb(stopStb), .wpIn(wpIn), .pendAny(pendAny), .curPage(curPage),
    .busy(busy), .strb(strb)
  );

  pageWriteDp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .addrLoadVal(addrLoadVal), .wrByteVal(wrByteVal),
    .curAddr(curAddr), .curPage(curPage), .pendAny(pendAny),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData)
  );
endmodule

// File: rtl/pageWriteChk.sv
`timescale 1ns/1ps
module pageWriteChk
  import pageWritePkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 addrLoadStb,
  input logic [ADDR_BITS-1:0] addrLoadVal,
  input logic                 wrByteStb,
  input logic                 rdAdvStb,
  input logic                 stopStb,
  input logic                 wpIn,
  input logic                 busy,
  input logic [ADDR_BITS-1:0] curAddr,
  input logic                 memWrEn,
  input logic [ADDR_BITS-1:0] memWrAddr
);
  // protect pin level seen at the last STOP accepted while idle
  logic capWp;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 capWp <= 1'b0;
    else if (stopStb && !busy) capWp <= wpIn;
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (curAddr == '0 && !busy && !memWrEn));

  p_load_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (addrLoadStb && !busy) |=> (curAddr == $past(addrLoadVal)));

  p_offset_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrByteStb && !addrLoadStb && !busy) |=>
      (curAddr[ADDR_BITS-1:OFF_BITS] == $past(curAddr[ADDR_BITS-1:OFF_BITS]) &&
       curAddr[OFF_BITS-1:0] == OFF_BITS'($past(curAddr[OFF_BITS-1:0]) + 1'b1)));

  p_full_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdAdvStb && !wrByteStb && !addrLoadStb && !busy) |=>
      (curAddr == ADDR_BITS'($past(curAddr) + 1'b1)));

  p_busy_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopStb));

  p_write_in_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> busy);

  p_protect_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && (&memWrAddr[ADDR_BITS-1 -: PROT_BITS])) |-> !capWp);

  p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(curAddr));
endmodule

bind pageWriteEngine pageWriteChk i_chk (
  .clk(clk), .rstN(rstN), .addrLoadStb(addrLoadStb), .addrLoadVal(addrLoadVal),
  .wrByteStb(wrByteStb), .rdAdvStb(rdAdvStb), .stopStb(stopStb), .wpIn(wpIn),
  .busy(busy), .curAddr(curAddr), .memWrEn(memWrEn), .memWrAddr(memWrAddr)
);

// File: tb/test_pageWriteEngine.sv
`timescale 1ns/1ps
module test_pageWriteEngine;
  localparam int BUSY = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrLoadStb = 1'b0;
  logic [12:0] addrLoadVal = '0;
  logic        wrByteStb = 1'b0;
  logic [7:0]  wrByteVal = '0;
  logic        rdAdvStb = 1'b0;
  logic        stopStb = 1'b0;
  logic        wpIn = 1'b0;
  logic        busy;
  logic [12:0] curAddr;
  logic        memWrEn;
  logic [12:0] memWrAddr;
  logic [7:0]  memWrData;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int logCnt = 0;
  logic [12:0] logAddr [256];
  logic [7:0]  logData [256];

  pageWriteEngine #(.BUSY_CYCLES(BUSY)) i_pageWriteEngine (
    .clk(clk), .rstN(rstN), .addrLoadStb(addrLoadStb), .addrLoadVal(addrLoadVal),
    .wrByteStb(wrByteStb), .wrByteVal(wrByteVal), .rdAdvStb(rdAdvStb),
    .stopStb(stopStb), .wpIn(wpIn), .busy(busy), .curAddr(curAddr),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

  always #10 clk = ~clk;

  // array write log and watchdog
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (memWrEn === 1'b1) begin
      logAddr[logCnt % 256] <= memWrAddr;
      logData[logCnt % 256] <= memWrData;
      logCnt <= logCnt + 1;
    end
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL R5 watchdog got=%0d exp<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic doLoad(int a);
    @(negedge clk); addrLoadStb = 1'b1; addrLoadVal = 13'(a);
    @(negedge clk); addrLoadStb = 1'b0;
  endtask

  task automatic doByte(logic [7:0] d);
    @(negedge clk); wrByteStb = 1'b1; wrByteVal = d;
    @(negedge clk); wrByteStb = 1'b0;
  endtask

  task automatic doAdv();
    @(negedge clk); rdAdvStb = 1'b1;
    @(negedge clk); rdAdvStb = 1'b0;
  endtask

  task automatic doStop();
    @(negedge clk); stopStb = 1'b1;
    @(negedge clk); stopStb = 1'b0;
  endtask

  task automatic measureBusy(output int n);
    n = 0;
    while (busy === 1'b1 && n < 100000) begin
      n++;
      @(negedge clk);
    end
    // let the log monitor settle this edge
    #1;
  endtask

  task automatic runWrite(int start, int n, bit wp, int seed);
    int off0 = start & 31;
    int page = start >> 5;
    logic [7:0] expD [32];
    bit hit [32];
    bit prot;
    int base, nb, expCnt, j;
    for (int o = 0; o < 32; o++) begin hit[o] = 0; expD[o] = '0; end
    doLoad(start);
    chk("R2 load", curAddr, start);
    for (int k = 0; k < n; k++) begin
      int o = (off0 + k) & 31;
      logic [7:0] d = 8'((seed + k * 37 + start) & 255);
      expD[o] = d;
      hit[o] = 1;
      doByte(d);
      chk("R3 offset step", curAddr, page * 32 + ((off0 + k + 1) & 31));
    end
    wpIn = wp;
    prot = wp && (page >= 192);
    #1 base = logCnt;
    doStop();
    wpIn = 1'b0;
    measureBusy(nb);
    chk("R5 busy length", nb, (n > 0) ? BUSY : 0);
    expCnt = 0;
    if (!prot) for (int o = 0; o < 32; o++) if (hit[o]) expCnt++;
    chk(prot ? "R7 protected count" : "R6 commit count", logCnt - base, expCnt);
    j = base;
    for (int o = 0; o < 32; o++) begin
      if (hit[o] && !prot && j < logCnt) begin
        chk("R6 commit addr", logAddr[j % 256], page * 32 + o);
        chk("R6 commit data", logData[j % 256], expD[o]);
        j++;
      end
    end
    chk("R3 addr after commit", curAddr, page * 32 + ((off0 + n) & 31));
  endtask

  initial begin
    int nb, base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset addr", curAddr, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset wr", memWrEn, 0);

    // R2 load sweep
    for (int i = 0; i < 24; i++) begin
      doLoad((i * 331 + 7) & 13'h1FFF);
      chk("R2 load sweep", curAddr, (i * 331 + 7) & 13'h1FFF);
    end

    // R4 full wrap on reads
    doLoad(13'h1FF0);
    for (int i = 0; i < 20; i++) begin
      doAdv();
      chk("R4 read advance", curAddr, (13'h1FF0 + i + 1) & 13'h1FFF);
    end

    // R3 R5 R6 length sweep across the page wrap
    for (int n = 0; n <= 33; n++) runWrite(9 * 32 + 29, n, 1'b0, n * 11);

    runWrite(13'h0000, 1, 1'b0, 3);
    runWrite(13'h0121, 40, 1'b0, 5);
    runWrite(13'h07FD, 7, 1'b0, 9);
    runWrite(13'h03E0, 32, 1'b0, 1);
    runWrite(13'h0040, 0, 1'b0, 2);
    // R7 protection corners
    runWrite(13'h1800, 4, 1'b1, 4);
    runWrite(13'h1800, 4, 1'b0, 6);
    runWrite(13'h17FE, 3, 1'b1, 8);
    runWrite(13'h1FFE, 3, 1'b1, 10);
    runWrite(13'h0400, 5, 1'b1, 12);

    // R10 load drops pending bytes
    doLoad(13'h0200);
    doByte(8'h01); doByte(8'h02); doByte(8'h03);
    doLoad(13'h0300);
    #1 base = logCnt;
    doStop();
    chk("R10 no busy after load", busy, 0);
    repeat (3) @(negedge clk);
    #1 chk("R10 no writes", logCnt - base, 0);
    chk("R10 addr", curAddr, 13'h0300);

    // R8 strobes ignored while busy
    doLoad(13'h00A0);
    doByte(8'h11); doByte(8'h22);
    #1 base = logCnt;
    doStop();
    repeat (3) @(negedge clk);
    addrLoadStb = 1'b1; addrLoadVal = 13'h1234; wrByteStb = 1'b1; wrByteVal = 8'hEE;
    rdAdvStb = 1'b1; stopStb = 1'b1;
    @(negedge clk);
    addrLoadStb = 1'b0; wrByteStb = 1'b0; rdAdvStb = 1'b0; stopStb = 1'b0;
    chk("R8 addr held in busy", curAddr, 13'h00A2);
    measureBusy(nb);
    chk("R8 writes only earlier bytes", logCnt - base, 2);
    chk("R8 addr after busy", curAddr, 13'h00A2);
    doStop();
    chk("R8 ignored byte not pending", busy, 0);

    // R9 final byte together with STOP
    doLoad(13'h01E0);
    doByte(8'h5A);
    #1 base = logCnt;
    @(negedge clk); wrByteStb = 1'b1; wrByteVal = 8'hC3; stopStb = 1'b1;
    @(negedge clk); wrByteStb = 1'b0; stopStb = 1'b0;
    measureBusy(nb);
    chk("R9 busy length", nb, BUSY);
    chk("R9 write count", logCnt - base, 2);
    if (logCnt - base == 2) begin
      chk("R9 last addr", logAddr[(base + 1) % 256], 13'h01E1);
      chk("R9 last data", logData[(base + 1) % 256], 8'hC3);
    end
    chk("R9 addr after", curAddr, 13'h01E2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule